// File: doc/BRIEF.md
# Buck Channel Light-Load Mode Selector

This block decides whether a synchronous buck channel runs in fixed-frequency PWM or in hysteretic operation, where both power switches rest between current pulses so that the lower switch behaves as a diode. Once per main-clock period, a strobe marks the instant at the end of lower-switch conduction, just before the upper switch would turn on. At that strobe the block takes the polarity of the switch-node comparator. A high sample means the switch node is positive, so inductor current has reversed. A low sample means it is negative, so current is flowing forward.

The block changes mode only after an unbroken run of samples that disagree with the present mode. This hysteresis keeps the mode from toggling when the load sits near the boundary. A second, faster path watches a flag raised when the output falls under the hysteretic lower limit. In hysteretic mode that flag returns the channel to PWM at the very next clock. On every mode change the block requests a short interval with both switches off, so the gate logic can let the switch node settle.

Top module: `buck_mode_ctrl`

## Requirements
- R1: After reset, `hyst_mode` is 0 (PWM) and `fets_off` is 0, and the run count is zero, so a full run of RUN_LEN (default 8) samples is needed for the first mode change.
- R2: `cmp_pos` is taken only in clock cycles where `smp_stb` is 1; its value in other cycles affects neither the mode nor the run count.
- R3: In PWM (`hyst_mode`=0), RUN_LEN consecutive strobed samples with `cmp_pos`=1 set `hyst_mode` to 1 from the clock edge that takes the last of them.
- R4: In PWM, a strobed sample with `cmp_pos`=0 clears the run, so a fresh RUN_LEN high samples are then needed.
- R5: In hysteretic mode (`hyst_mode`=1), RUN_LEN consecutive strobed samples with `cmp_pos`=0 clear `hyst_mode` to 0 from the edge that takes the last of them.
- R6: In hysteretic mode, a strobed sample with `cmp_pos`=1 clears the run.
- R7: In hysteretic mode, `vout_low`=1 at a clock edge clears `hyst_mode` at that edge with no sample needed; in PWM, `vout_low` has no effect.
- R8: Every mode change, including one caused by `vout_low`, clears the run, so samples gathered before the change do not count toward the next one.
- R9: `fets_off` is 1 for exactly OFF_CYC (default 2) cycles starting in the first cycle of the new mode, for both directions of change, and 0 otherwise.
- R10: If `vout_low` and the last sample of a return run arrive in the same cycle, a single change to PWM occurs with one OFF_CYC-long `fets_off` pulse.

Top module parameters: RUN_LEN (run length, at least 2), OFF_CYC (off-request length, at least 1), FAST_EXIT_EN (1 includes the `vout_low` path).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | End-of-lower-conduction sampling strobe |
| cmp_pos | input | 1 | Switch-node comparator: 1 positive, 0 negative |
| vout_low | input | 1 | Output under hysteretic lower limit |
| hyst_mode | output | 1 | 1 hysteretic, 0 PWM |
| fets_off | output | 1 | Request to hold both switches off |

## Verification
The two paths that can collide are the fast return on `vout_low` and the run counter finishing a return to PWM. The bench provokes the collision by arranging for a run of seven low samples in hysteretic mode, then sending the eighth low sample with `vout_low` raised in the same cycle. The bench judges the result at the ports. Exactly one change to PWM must occur, `fets_off` must stay high for OFF_CYC cycles and then fall, and seven following high samples must leave the mode unchanged, which shows that the run was cleared only once and cleanly.

// File: rtl/buck_mode_pkg.sv
package buck_mode_pkg;

   typedef enum logic {
      MODE_PWM  = 1'b0,
      MODE_HYST = 1'b1
   } op_mode_e;

   // a sample argues for leaving the present mode
   function automatic logic opposes_mode(input op_mode_e mode, input logic node_pos);
      return (mode == MODE_PWM) ? node_pos : ~node_pos;
   endfunction

endpackage

// File: rtl/buck_mode_runcnt.sv
module buck_mode_runcnt #(
   parameter int RUN_LEN = 8,
   localparam int CNT_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_vld,
   input  logic smp_opp,
   input  logic clr,
   output logic run_done
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

   logic [CNT_W-1:0] cnt_q;

   initial assert (RUN_LEN >= 2) else $error("RUN_LEN must be at least 2");

   assign run_done = smp_vld && smp_opp && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (smp_vld) begin
         if (smp_opp) cnt_q <= cnt_q + CNT_W'(1);
         else         cnt_q <= '0;
      end
   end

   // the run never counts past its last step
   assert_run_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // a mode flip leaves the run empty
   assert_clear_on_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

   // a sample that agrees with the present mode breaks the run
   assert_break_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !smp_opp) |=> (cnt_q == '0));

   // without a strobe the run holds still
   assert_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_vld && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/buck_mode_fsm.sv
module buck_mode_fsm
   import buck_mode_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run_done,
   input  logic     fast_req,
   output op_mode_e mode,
   output logic     flip
);

   op_mode_e mode_q;

   // fast_req is only raised while hysteretic, so either source means a toggle
   assign flip = run_done || fast_req;
   assign mode = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_PWM;
      end else if (flip) begin
         mode_q <= (mode_q == MODE_PWM) ? MODE_HYST : MODE_PWM;
      end
   end

   // entry into hysteretic mode only ends a completed run
   assert_entry_by_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_q) |-> $past(run_done));

   // a fast request never arrives in PWM
   assert_fast_only_hyst_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fast_req |-> (mode_q == MODE_HYST));

endmodule

// File: rtl/buck_mode_blank.sv
module buck_mode_blank #(
   parameter int OFF_CYC = 2,
   localparam int BW = $clog2(OFF_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic fets_off
);

   logic [BW-1:0] left_q;

   initial assert (OFF_CYC >= 1) else $error("OFF_CYC must be at least 1");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (load) begin
         left_q <= BW'(OFF_CYC);
      end else if (left_q != '0) begin
         left_q <= left_q - BW'(1);
      end
   end

   assign fets_off = (left_q != '0);

   // a load always opens the off window
   assert_load_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> fets_off);

endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl
   import buck_mode_pkg::*;
#(
   parameter int RUN_LEN      = 8,
   parameter int OFF_CYC      = 2,
   parameter bit FAST_EXIT_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_stb,
   input  logic cmp_pos,
   input  logic vout_low,
   output logic hyst_mode,
   output logic fets_off
);

   op_mode_e mode;
   logic     flip;
   logic     run_done;
   logic     fast_req;
   logic     smp_opp;

   assign smp_opp = opposes_mode(mode, cmp_pos);

   generate
      if (FAST_EXIT_EN) begin : g_fast
         assign fast_req = (mode == MODE_HYST) && vout_low;

         // output dip in hysteretic mode returns to PWM at once
         assert_fast_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (hyst_mode && vout_low) |=> !hyst_mode);
      end else begin : g_nofast
         assign fast_req = 1'b0;
      end
   endgenerate

   buck_mode_runcnt #(.RUN_LEN(RUN_LEN)) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_vld  (smp_stb),
      .smp_opp  (smp_opp),
      .clr      (flip),
      .run_done (run_done)
   );

   buck_mode_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_done (run_done),
      .fast_req (fast_req),
      .mode     (mode),
      .flip     (flip)
   );

   buck_mode_blank #(.OFF_CYC(OFF_CYC)) u_blank (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (flip),
      .fets_off (fets_off)
   );

   assign hyst_mode = (mode == MODE_HYST);

   // every mode change comes with a both-off request
   assert_flip_blanked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hyst_mode) |-> fets_off);

   // the mode never moves without a strobe or an output dip
   assert_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_stb && !vout_low) |=> $stable(hyst_mode));

endmodule

// File: tb/buck_mode_ctrl_bench.sv
module buck_mode_ctrl_bench;

   localparam int RUN = 8;
   localparam int OFF = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_stb = 1'b0;
   logic cmp_pos = 1'b0;
   logic vout_low = 1'b0;
   logic hyst_mode;
   logic fets_off;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   buck_mode_ctrl #(.RUN_LEN(RUN), .OFF_CYC(OFF), .FAST_EXIT_EN(1'b1)) u_buck_mode_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_stb   (smp_stb),
      .cmp_pos   (cmp_pos),
      .vout_low  (vout_low),
      .hyst_mode (hyst_mode),
      .fets_off  (fets_off)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0b expected %0b", req, act, exp);
      end
   endtask

   // one strobed sample; returns at the next falling edge with outputs settled
   task automatic samp(input logic pos, input logic vl);
      smp_stb = 1'b1; cmp_pos = pos; vout_low = vl;
      @(negedge clk);
      smp_stb = 1'b0; vout_low = 1'b0;
   endtask

   task automatic idle(input int n, input logic pos);
      cmp_pos = pos;
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // called in the first cycle of the new mode
   task automatic expect_flip(input string req, input logic exp_mode);
      chk(req, hyst_mode, exp_mode);
      chk({req, " off window first"}, fets_off, 1'b1);
      for (int i = 1; i < OFF; i++) begin
         @(negedge clk);
         chk({req, " off window held"}, fets_off, 1'b1);
      end
      @(negedge clk);
      chk({req, " off window closed"}, fets_off, 1'b0);
      chk({req, " mode kept"}, hyst_mode, exp_mode);
   endtask

   task automatic t_reset;
      chk("R1 reset mode", hyst_mode, 1'b0);
      chk("R1 reset off", fets_off, 1'b0);
      idle(2, 1'b1);
      chk("R1 idle mode", hyst_mode, 1'b0);
   endtask

   task automatic t_enter;
      for (int i = 0; i < RUN - 1; i++) begin
         samp(1'b1, 1'b0);
         chk("R1 partial run", hyst_mode, 1'b0);
      end
      samp(1'b1, 1'b0);
      expect_flip("R3 enter hyst", 1'b1);
   endtask

   task automatic t_ignore_unstrobed;
      idle(12, 1'b0);
      chk("R2 unstrobed low in hyst", hyst_mode, 1'b1);
      chk("R2 no off request", fets_off, 1'b0);
      for (int i = 0; i < RUN - 1; i++) samp(1'b0, 1'b0);
      chk("R5 seven lows", hyst_mode, 1'b1);
      samp(1'b0, 1'b0);
      expect_flip("R5 return pwm", 1'b0);
      for (int i = 0; i < 4; i++) samp(1'b1, 1'b0);
      idle(10, 1'b0);
      chk("R2 unstrobed low in pwm", hyst_mode, 1'b0);
      for (int i = 0; i < 3; i++) samp(1'b1, 1'b0);
      chk("R2 run continues", hyst_mode, 1'b0);
      samp(1'b1, 1'b0);
      expect_flip("R2 run intact enter hyst", 1'b1);
   endtask

   task automatic t_hyst_break;
      for (int i = 0; i < RUN - 1; i++) samp(1'b0, 1'b0);
      samp(1'b1, 1'b0);
      for (int i = 0; i < RUN - 1; i++) samp(1'b0, 1'b0);
      chk("R6 broken run stays hyst", hyst_mode, 1'b1);
      samp(1'b0, 1'b0);
      expect_flip("R6 fresh run to pwm", 1'b0);
   endtask

   task automatic t_pwm_break;
      for (int i = 0; i < RUN - 1; i++) samp(1'b1, 1'b0);
      samp(1'b0, 1'b0);
      for (int i = 0; i < RUN - 1; i++) samp(1'b1, 1'b0);
      chk("R4 broken run stays pwm", hyst_mode, 1'b0);
      samp(1'b1, 1'b0);
      expect_flip("R4 fresh run to hyst", 1'b1);
   endtask

   task automatic t_fast;
      vout_low = 1'b1;
      @(negedge clk);
      vout_low = 1'b0;
      expect_flip("R7 fast exit", 1'b0);
      vout_low = 1'b1;
      idle(5, 1'b0);
      vout_low = 1'b0;
      chk("R7 dip ignored in pwm", hyst_mode, 1'b0);
      chk("R7 no off in pwm", fets_off, 1'b0);
   endtask

   task automatic t_fresh;
      for (int i = 0; i < RUN; i++) samp(1'b1, 1'b0);
      idle(OFF + 1, 1'b0);
      chk("R8 setup hyst", hyst_mode, 1'b1);
      for (int i = 0; i < 4; i++) samp(1'b0, 1'b0);
      vout_low = 1'b1;
      @(negedge clk);
      vout_low = 1'b0;
      chk("R8 fast exit", hyst_mode, 1'b0);
      idle(OFF + 1, 1'b0);
      for (int i = 0; i < RUN - 4; i++) samp(1'b1, 1'b0);
      chk("R8 old run discarded", hyst_mode, 1'b0);
      for (int i = 0; i < 3; i++) samp(1'b1, 1'b0);
      chk("R8 seven fresh", hyst_mode, 1'b0);
      samp(1'b1, 1'b0);
      expect_flip("R8 fresh run to hyst", 1'b1);
   endtask

   task automatic t_collide;
      for (int i = 0; i < RUN - 1; i++) samp(1'b0, 1'b0);
      chk("R10 before collision", hyst_mode, 1'b1);
      samp(1'b0, 1'b1);
      expect_flip("R10 single exit", 1'b0);
      for (int i = 0; i < RUN - 1; i++) samp(1'b1, 1'b0);
      chk("R10 run cleared once", hyst_mode, 1'b0);
      chk("R10 no extra off", fets_off, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enter();
      t_ignore_unstrobed();
      t_hyst_break();
      t_pwm_break();
      t_fast();
      t_fresh();
      t_collide();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule